// File: doc/BRIEF.md
# HDLC Frame Transmitter with Programmable Underrun Handling

This block turns a byte stream into a bit-oriented HDLC serial line. Bytes arrive on a valid/ready stream with an end-of-frame marker and go out least significant bit first. The block adds the opening and closing flags and inserts a zero after every run of five ones in the frame body. When enabled, it appends a 16-bit CRC-CCITT frame check sequence. Between frames the line carries continuous flags. One bit leaves on every clock cycle in which `bit_en` is high, so the line rate is the clock rate gated by that enable.

A frame can end in three ways. The first is the end-of-frame marker. The second is a programmed byte count, which closes the frame automatically. The third is an underrun, which happens when no byte is ready at a byte boundary. For an underrun, a two-bit action code selects abort, extended abort, closing flag, or CRC followed by a closing flag. The `frame_done` output pulses with the last bit of every closing flag. The `underrun` output pulses when an underrun is detected.

The controller has six named states:

- `ST_IDLE` sends idle flags.
- `ST_DATA` sends payload bits.
- `ST_CRC` sends the complemented CRC.
- `ST_CLOSE` sends the closing flag.
- `ST_ABORT` sends seven ones.
- `ST_XABORT` sends fifteen ones.

The transitions are as follows:

- **Start:** `ST_IDLE` or `ST_CLOSE` moves to `ST_DATA` at the end of a flag when a byte is offered.
- **Close:** `ST_DATA` moves to `ST_CRC` or `ST_CLOSE` at the end of the last byte of a frame.
- **Underrun:** `ST_DATA` moves to `ST_ABORT`, `ST_XABORT`, `ST_CLOSE` or `ST_CRC` when no byte is ready at a byte boundary.
- **CRC end:** `ST_CRC` moves to `ST_CLOSE` after sixteen CRC bits.
- **Flag end:** `ST_CLOSE` moves to `ST_IDLE` when no byte is waiting.
- **Abort end:** `ST_ABORT` and `ST_XABORT` move to `ST_IDLE`.

Top module: `hdlc_tx`

## Requirements
- R1: While `rst_n` is low, `txd` is 1 and `s_ready`, `frame_done` and `underrun` are 0.
- R2: Outside a frame, the line carries back-to-back flags 8'h7E, sent bit 0 first. `s_ready` is high only in an enabled cycle that sends the last bit of a flag, or the last bit of a byte that does not end the frame. A byte is taken when `s_valid` and `s_ready` are both high.
- R3: Payload bytes are sent bit 0 first. After five consecutive 1 bits of payload or CRC, one 0 is inserted. A pending insertion is also made before a closing flag. Flags and abort runs are never stuffed.
- R4: With `cfg_crc_en` = 1, the frame check sequence follows the last byte. It uses the reflected polynomial 16'h8408, starts from 16'hFFFF over the payload bits, and is sent complemented, bit 0 first. With `cfg_crc_en` = 0, the closing flag follows the last byte directly.
- R5: A byte with `s_last` = 1 ends the frame. `frame_done` is high for one cycle, on the edge that drives the last bit of the closing flag. A byte offered in that cycle starts the next frame, with no extra flag in between.
- R6: With `cfg_len_en` = 1 and a nonzero `cfg_len`, the frame closes after byte number `cfg_len`, as if that byte carried `s_last`. A `cfg_len` of 0 sets no limit.
- R7: If `s_valid` is low when the last bit of a non-final byte goes out, `underrun` is high for one cycle on that same edge. The frame then ends according to `cfg_urun_act`.
- R8: For `cfg_urun_act` = 2'b00, seven 1 bits follow, then a full idle flag. No `frame_done` pulse is given.
- R9: For `cfg_urun_act` = 2'b01, fifteen 1 bits follow, then a full idle flag. No `frame_done` pulse is given.
- R10: For `cfg_urun_act` = 2'b10, a closing flag follows, with any pending stuffed zero first, and `frame_done` pulses.
- R11: For `cfg_urun_act` = 2'b11, the CRC is sent even when `cfg_crc_en` = 0. A closing flag and a `frame_done` pulse follow.
- R12: In a cycle with `bit_en` low, `txd` holds its value, nothing advances, and `s_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-time enable; one line bit per enabled cycle |
| cfg_crc_en | input | 1 | Append CRC-CCITT on normal close |
| cfg_urun_act | input | 2 | Underrun action code |
| cfg_len_en | input | 1 | Enable automatic close by byte count |
| cfg_len | input | LEN_W | Bytes per frame when the count limit is enabled |
| s_valid | input | 1 | Byte offered |
| s_data | input | DATA_W | Byte value |
| s_last | input | 1 | Byte is the last of its frame |
| s_ready | output | 1 | Byte taken this cycle if `s_valid` |
| txd | output | 1 | Serial line |
| frame_done | output | 1 | Pulse with last bit of closing flag |
| underrun | output | 1 | Pulse when an underrun is detected |

## Verification
The hardest situations to reach are the ones that overlap. In one, a pending stuffed zero coincides with the start of a closing flag produced by an underrun. In another, a count-limited close is followed at once by a new frame on a shared flag. The bench reaches the first by queueing a body that ends in five ones with no end marker, so the stream runs dry exactly at that byte boundary. It reaches the second by offering more bytes than the programmed limit. A behavioural line model, built from queues of expected bits, is advanced on every enabled cycle. It follows each byte hand-off, and the bench compares `txd`, `s_ready` and both pulses on every clock, with the enable both solid and randomly gated.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC,
        ST_CLOSE,
        ST_ABORT,
        ST_XABORT
    } tx_state_t;

    typedef enum logic [1:0] {
        UR_ABORT    = 2'b00,
        UR_XABORT   = 2'b01,
        UR_FLAG     = 2'b10,
        UR_CRC_FLAG = 2'b11
    } urun_act_t;

    localparam logic [7:0] FLAG_PATTERN = 8'h7E;
    localparam int         FLAG_BITS    = 8;

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
    parameter int            CRC_W = 16,
    parameter logic [15:0]   POLY  = 16'h8408
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic upd,
    input  logic din,
    input  logic shift,
    output logic crc_bit
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= {1'b0, crc_q[CRC_W-1:1]}
                     ^ ((crc_q[0] ^ din) ? POLY[CRC_W-1:0] : '0);
        end else if (shift) begin
            crc_q <= {1'b1, crc_q[CRC_W-1:1]};
        end
    end

    // The check sequence goes out complemented, low bit first.
    assign crc_bit = ~crc_q[0];

endmodule

// File: rtl/hdlc_tx_ones.sv
module hdlc_tx_ones #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic bit_in,
    output logic stuff_due
);
    localparam int OW = $clog2(RUN + 1);

    logic [OW-1:0] ones_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ones_q <= '0;
        end else if (en) begin
            ones_q <= bit_in ? ones_q + 1'b1 : '0;
        end
    end

    assign stuff_due = (ones_q == OW'(RUN));

endmodule

// File: rtl/hdlc_tx_len.sv
module hdlc_tx_len #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             inc,
    input  logic             lim_en,
    input  logic [LEN_W-1:0] limit,
    output logic             hit
);
    logic [LEN_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (start) begin
            count_q <= LEN_W'(1);
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign hit = lim_en && (limit != '0) && (count_q == limit);

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 16,
    parameter int CRC_W       = 16,
    parameter int STUFF_RUN   = 5,
    parameter int ABORT_ONES  = 7,
    parameter int XABORT_ONES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              cfg_crc_en,
    input  logic [1:0]        cfg_urun_act,
    input  logic              cfg_len_en,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              txd,
    output logic              frame_done,
    output logic              underrun
);
    localparam int MAXRUN = (CRC_W > XABORT_ONES) ? CRC_W : XABORT_ONES;
    localparam int CNT_W  = $clog2(MAXRUN > DATA_W ? MAXRUN : DATA_W);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int FIX_W  = $clog2(FLAG_BITS);

    tx_state_t         state, nstate;
    logic [CNT_W-1:0]  cnt_q, ncnt;
    logic [DATA_W-1:0] shreg_q;
    logic              last_q;
    logic              txd_q, bit_nxt;
    logic              done_q, done_nxt;
    logic              urun_q, urun_nxt;

    logic ready_c, load, first_byte;
    logic crc_upd, crc_shift, crc_bit;
    logic ones_en, ones_clr, stuff_due;
    logic len_hit;

    hdlc_tx_crc #(.CRC_W(CRC_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (first_byte),
        .upd     (crc_upd),
        .din     (bit_nxt),
        .shift   (crc_shift),
        .crc_bit (crc_bit)
    );

    hdlc_tx_ones #(.RUN(STUFF_RUN)) u_ones (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ones_en),
        .clr       (ones_clr),
        .bit_in    (bit_nxt),
        .stuff_due (stuff_due)
    );

    hdlc_tx_len #(.LEN_W(LEN_W)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (first_byte),
        .inc    (load && !first_byte),
        .lim_en (cfg_len_en),
        .limit  (cfg_len),
        .hit    (len_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state and per-bit controls
    always_comb begin
        nstate     = state;
        ncnt       = cnt_q;
        bit_nxt    = txd_q;
        ready_c    = 1'b0;
        load       = 1'b0;
        first_byte = 1'b0;
        crc_upd    = 1'b0;
        crc_shift  = 1'b0;
        ones_en    = 1'b0;
        ones_clr   = 1'b0;
        done_nxt   = 1'b0;
        urun_nxt   = 1'b0;
        if (bit_en) begin
            unique case (state)
                ST_IDLE: begin
                    ones_clr = 1'b1;
                    bit_nxt  = FLAG_PATTERN[cnt_q[FIX_W-1:0]];
                    if (cnt_q == CNT_W'(FLAG_BITS - 1)) begin
                        ncnt    = '0;
                        ready_c = 1'b1;
                        if (s_valid) begin
                            load       = 1'b1;
                            first_byte = 1'b1;
                            nstate     = ST_DATA;
                        end
                    end else begin
                        ncnt = cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    ones_en = 1'b1;
                    if (stuff_due) begin
                        bit_nxt = 1'b0;
                    end else begin
                        bit_nxt = shreg_q[cnt_q[IDX_W-1:0]];
                        crc_upd = 1'b1;
                        if (cnt_q == CNT_W'(DATA_W - 1)) begin
                            ncnt = '0;
                            if (last_q || len_hit) begin
                                nstate = cfg_crc_en ? ST_CRC : ST_CLOSE;
                            end else begin
                                ready_c = 1'b1;
                                if (s_valid) begin
                                    load = 1'b1;
                                end else begin
                                    urun_nxt = 1'b1;
                                    unique case (urun_act_t'(cfg_urun_act))
                                        UR_ABORT:    nstate = ST_ABORT;
                                        UR_XABORT:   nstate = ST_XABORT;
                                        UR_FLAG:     nstate = ST_CLOSE;
                                        UR_CRC_FLAG: nstate = ST_CRC;
                                    endcase
                                end
                            end
                        end else begin
                            ncnt = cnt_q + 1'b1;
                        end
                    end
                end
                ST_CRC: begin
                    ones_en = 1'b1;
                    if (stuff_due) begin
                        bit_nxt = 1'b0;
                    end else begin
                        bit_nxt   = crc_bit;
                        crc_shift = 1'b1;
                        if (cnt_q == CNT_W'(CRC_W - 1)) begin
                            ncnt   = '0;
                            nstate = ST_CLOSE;
                        end else begin
                            ncnt = cnt_q + 1'b1;
                        end
                    end
                end
                ST_CLOSE: begin
                    ones_clr = 1'b1;
                    if (stuff_due) begin
                        bit_nxt = 1'b0;
                    end else begin
                        bit_nxt = FLAG_PATTERN[cnt_q[FIX_W-1:0]];
                        if (cnt_q == CNT_W'(FLAG_BITS - 1)) begin
                            ncnt     = '0;
                            done_nxt = 1'b1;
                            ready_c  = 1'b1;
                            if (s_valid) begin
                                load       = 1'b1;
                                first_byte = 1'b1;
                                nstate     = ST_DATA;
                            end else begin
                                nstate = ST_IDLE;
                            end
                        end else begin
                            ncnt = cnt_q + 1'b1;
                        end
                    end
                end
                ST_ABORT: begin
                    ones_clr = 1'b1;
                    bit_nxt  = 1'b1;
                    if (cnt_q == CNT_W'(ABORT_ONES - 1)) begin
                        ncnt   = '0;
                        nstate = ST_IDLE;
                    end else begin
                        ncnt = cnt_q + 1'b1;
                    end
                end
                ST_XABORT: begin
                    ones_clr = 1'b1;
                    bit_nxt  = 1'b1;
                    if (cnt_q == CNT_W'(XABORT_ONES - 1)) begin
                        ncnt   = '0;
                        nstate = ST_IDLE;
                    end else begin
                        ncnt = cnt_q + 1'b1;
                    end
                end
                default: begin
                    nstate = ST_IDLE;
                    ncnt   = '0;
                end
            endcase
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            last_q  <= 1'b0;
            txd_q   <= 1'b1;
            done_q  <= 1'b0;
            urun_q  <= 1'b0;
        end else begin
            cnt_q  <= ncnt;
            txd_q  <= bit_nxt;
            done_q <= done_nxt;
            urun_q <= urun_nxt;
            if (load) begin
                shreg_q <= s_data;
                last_q  <= s_last;
            end
        end
    end

    assign s_ready    = ready_c;
    assign txd        = txd_q;
    assign frame_done = done_q;
    assign underrun   = urun_q;

endmodule

// File: rtl/hdlc_tx_checks.sv
module hdlc_tx_checks (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic s_ready,
    input logic txd,
    input logic frame_done,
    input logic underrun
);
    // R12: no hand-off outside an enabled bit time
    a_r12_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> bit_en);

    // R12: the line holds when the enable is low
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(txd));

    // R5: the completion pulse lines up with the final 0 of a flag
    a_r5_done_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (txd == 1'b0));

    // R5: the completion pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7: underrun and completion never share a cycle
    a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && underrun));

    // R7: the underrun pulse lasts one cycle
    a_r7_urun_single: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

endmodule

bind hdlc_tx hdlc_tx_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .s_ready    (s_ready),
    .txd        (txd),
    .frame_done (frame_done),
    .underrun   (underrun)
);

// File: tb/hdlc_tx_test.sv
`timescale 1ns/1ps
module hdlc_tx_test;

    localparam int M_IDLE = 0, M_CLOSE = 1, M_DATA = 2, M_CRC = 3, M_ABORT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        cfg_crc_en = 1'b1;
    logic [1:0]  cfg_urun_act = 2'b00;
    logic        cfg_len_en = 1'b0;
    logic [15:0] cfg_len = 16'd0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_last = 1'b0;
    logic        s_ready, txd, frame_done, underrun;

    hdlc_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .cfg_crc_en(cfg_crc_en), .cfg_urun_act(cfg_urun_act),
        .cfg_len_en(cfg_len_en), .cfg_len(cfg_len),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .txd(txd), .frame_done(frame_done), .underrun(underrun)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    string req_tag  = "R1";
    bit    gated    = 1'b0;
    bit    took     = 1'b0;
    bit    model_on = 1'b0;
    int    done_seen = 0;
    int    urun_seen = 0;

    // stimulus source: {last, data}
    logic [8:0] src[$];

    // reference model
    bit          mq[$];
    int          mstate = M_IDLE;
    int          m_ones = 0;
    int          m_cnt  = 0;
    bit          m_last = 1'b0;
    logic [15:0] m_crc  = 16'hFFFF;
    bit          exp_txd = 1'b1;
    bit          exp_done = 1'b0;
    bit          exp_urun = 1'b0;
    bit          exp_ready;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    task automatic push_payload(input bit b);
        if (m_ones == 5) begin
            mq.push_back(1'b0);
            m_ones = 0;
        end
        mq.push_back(b);
        m_ones = b ? m_ones + 1 : 0;
    endtask

    task automatic push_flag();
        logic [7:0] f = 8'h7E;
        if (m_ones == 5) mq.push_back(1'b0);
        m_ones = 0;
        for (int i = 0; i < 8; i++) mq.push_back(f[i]);
    endtask

    task automatic push_ones(input int n);
        for (int i = 0; i < n; i++) mq.push_back(1'b1);
        m_ones = 0;
    endtask

    task automatic push_crc();
        logic [15:0] c = m_crc;
        for (int i = 0; i < 16; i++) push_payload(~c[i]);
    endtask

    task automatic take_byte(input bit first);
        if (first) begin
            m_crc = 16'hFFFF;
            m_cnt = 1;
        end else begin
            m_cnt++;
        end
        m_last = s_last;
        for (int i = 0; i < 8; i++) begin
            bit b = s_data[i];
            push_payload(b);
            m_crc = (m_crc >> 1) ^ (((m_crc[0] ^ b) != 1'b0) ? 16'h8408 : 16'h0000);
        end
    endtask

    task automatic decide(output bit nd, output bit nu);
        nd = 1'b0;
        nu = 1'b0;
        case (mstate)
            M_IDLE, M_CLOSE: begin
                nd = (mstate == M_CLOSE);
                exp_ready = 1'b1;
                if (s_valid) begin
                    take_byte(1'b1);
                    mstate = M_DATA;
                end else begin
                    push_flag();
                    mstate = M_IDLE;
                end
            end
            M_DATA: begin
                if (m_last || (cfg_len_en && cfg_len != 0 && m_cnt == int'(cfg_len))) begin
                    if (cfg_crc_en) begin push_crc(); mstate = M_CRC; end
                    else begin push_flag(); mstate = M_CLOSE; end
                end else begin
                    exp_ready = 1'b1;
                    if (s_valid) begin
                        take_byte(1'b0);
                    end else begin
                        nu = 1'b1;
                        case (cfg_urun_act)
                            2'b00: begin push_ones(7);  mstate = M_ABORT; end
                            2'b01: begin push_ones(15); mstate = M_ABORT; end
                            2'b10: begin push_flag();   mstate = M_CLOSE; end
                            default: begin push_crc();  mstate = M_CRC; end
                        endcase
                    end
                end
            end
            M_CRC: begin
                push_flag();
                mstate = M_CLOSE;
            end
            default: begin
                push_flag();
                mstate = M_IDLE;
            end
        endcase
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit nd, nu;
        if (!rst_n) begin
            mq.delete();
            push_flag();
            mstate   = M_IDLE;
            m_ones   = 0;
            exp_txd  = 1'b1;
            exp_done = 1'b0;
            exp_urun = 1'b0;
            took     = 1'b0;
        end else if (model_on) begin
            check({req_tag, " txd"}, txd, exp_txd);
            check("R5 frame_done", frame_done, exp_done);
            check("R7 underrun", underrun, exp_urun);
            if (frame_done) done_seen++;
            if (underrun)   urun_seen++;
            exp_ready = 1'b0;
            nd = 1'b0;
            nu = 1'b0;
            if (bit_en) begin
                if (mq.size() == 1) decide(nd, nu);
                exp_txd = mq.pop_front();
            end
            exp_done = nd;
            exp_urun = nu;
            check(bit_en ? "R2 s_ready" : "R12 s_ready", s_ready, exp_ready);
            took = s_ready && s_valid;
        end
    end

    // input driver
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (took && src.size() > 0) void'(src.pop_front());
            took   = 1'b0;
            bit_en = gated ? (($urandom % 4) != 0) : 1'b1;
            if (!rst_n) bit_en = 1'b0;
            s_valid = (src.size() > 0);
            {s_last, s_data} = (src.size() > 0) ? src[0] : 9'h000;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            finish_run();
        end
    end

    task automatic run_frame(input string tag, input logic [7:0] bytes[$], input bit end_mark,
                             input int want_done, input int want_urun);
        req_tag   = tag;
        done_seen = 0;
        urun_seen = 0;
        @(posedge clk);
        #2;
        foreach (bytes[i])
            src.push_back({(end_mark && i == bytes.size() - 1), bytes[i]});
        wait (src.size() == 0);
        repeat (160) @(posedge clk);
        check({tag, " frame_done count"}, done_seen, want_done);
        check({tag, " underrun count"}, urun_seen, want_urun);
    endtask

    initial begin
        logic [7:0] b[$];
        repeat (4) @(posedge clk);
        #3;
        // R1: reset values
        check("R1 txd", txd, 1);
        check("R1 s_ready", s_ready, 0);
        check("R1 frame_done", frame_done, 0);
        check("R1 underrun", underrun, 0);
        @(posedge clk);
        #1;
        rst_n    = 1'b1;
        model_on = 1'b1;
        repeat (30) @(posedge clk);

        // R2 R3 R4: stuffing-heavy frame with CRC
        b = '{8'hFF, 8'hFF, 8'h7E, 8'h1F, 8'hF8, 8'h3E};
        run_frame("R2/R3/R4", b, 1'b1, 1, 0);

        // R5 R12: two back-to-back frames with gated enable
        gated = 1'b1;
        b = '{8'h81, 8'hFE, 8'h55, 8'hC3};
        req_tag = "R5/R12";
        @(posedge clk); #2;
        src.push_back({1'b0, 8'h81}); src.push_back({1'b1, 8'hFE});
        src.push_back({1'b0, 8'h55}); src.push_back({1'b1, 8'hC3});
        done_seen = 0; urun_seen = 0;
        wait (src.size() == 0);
        repeat (160) @(posedge clk);
        check("R5 two frames done", done_seen, 2);
        gated = 1'b0;

        // R4: no CRC
        cfg_crc_en = 1'b0;
        b = '{8'hA5, 8'h0F};
        run_frame("R4", b, 1'b1, 1, 0);
        cfg_crc_en = 1'b1;

        // R6: count limit of 3 over five bytes, end mark on the fifth
        cfg_len_en = 1'b1;
        cfg_len    = 16'd3;
        b = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        run_frame("R6", b, 1'b1, 2, 0);
        cfg_len_en = 1'b0;
        cfg_len    = 16'd0;

        // R7 R8: abort
        cfg_urun_act = 2'b00;
        b = '{8'hFF, 8'h3C};
        run_frame("R7/R8", b, 1'b0, 0, 1);

        // R9: extended abort, gated
        gated = 1'b1;
        cfg_urun_act = 2'b01;
        b = '{8'h9A, 8'hF0};
        run_frame("R9", b, 1'b0, 0, 1);
        gated = 1'b0;

        // R10: closing flag, body ends in five ones
        cfg_urun_act = 2'b10;
        b = '{8'h12, 8'hF8};
        run_frame("R10", b, 1'b0, 1, 1);

        // R11: CRC then flag with CRC disabled
        cfg_crc_en   = 1'b0;
        cfg_urun_act = 2'b11;
        b = '{8'h55, 8'hF8};
        run_frame("R11", b, 1'b0, 1, 1);

        finish_run();
    end

endmodule